// File: doc/BRIEF.md
# Interpolated Electrical Angle Generator

This block turns the coarse rotor position from a Hall-sensor speed estimator into a smooth electrical angle, measured in degrees. The estimator supplies several values: the 60-degree sector index, the direction of rotation, a tick counter that runs since the last Hall edge, and the captured length of the previous sector in ticks. The block scales the ratio of counter to period into the current sector, which gives a raw angle.

A phase advance can be added when the motor turns fast enough. The advance comes from an 11-point piecewise-linear table, indexed by the magnitude of the signed duty command over evenly spaced breakpoints. It is applied in the direction of rotation, and the sum is folded into 0..359 by floor-modulo. When the advance is not applied, the advanced output simply carries the raw angle.

Each result is computed over two clock cycles after a `tick_i` strobe and is announced by `valid_o`. Dropping `en_i` selects the control mode without angle generation: it forces both angle outputs to zero.

Top module: `elec_angle_gen`

## Requirements
- R1: During and after reset, before any tick, `angle_raw_o`, `angle_adv_o` and `valid_o` are all 0.
- R2: A `tick_i` sampled high with `en_i` high at clock edge k gives `valid_o` high for exactly the cycle after edge k+1, with both angles updated at that same edge.
- R3: The raw angle uses direction encoding `dir_rev_i`=0 for +1 and 1 for -1. It is base*60 + d*q, where q = (60*cnt) / period, truncated toward zero. Here d is the direction sign, and base is `pos_i` for +1 and `pos_i`+1 for -1.
- R4: The advance is applied only when `adv_en_i` is 1 and `speed_abs_i` is strictly greater than `spd_thr_i`. Otherwise `angle_adv_o` equals `angle_raw_o` unchanged, with no wrap, so it can read 360.
- R5: A duty magnitude at or below `bp_start_i` selects table entry 0 exactly.
- R6: A duty magnitude at or beyond `bp_start_i` + 10*`bp_step_i` yields table entry 10 exactly. This uses the clip to the last interval with a fraction of 1.0.
- R7: Between breakpoints, the segment is i = (|duty|-start)/step and the fraction is f = (remainder << 31)/step. The advance is t[i] + floor((t[i+1]-t[i])*f / 2^31). Table entry k occupies bits [16k+15:16k] of `adv_tab_i`.
- R8: When the advance is applied, `angle_adv_o` = (d*advance + raw) floor-mod 360, always within 0..359, including for negative sums.
- R9: While `en_i` is 0, both angle outputs read 0 from the next edge on, ticks are ignored, and a result already in flight is discarded without raising `valid_o`.
- R10: Between results, both angle outputs hold their last values even if the data inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Angle function enable; 0 forces the outputs to zero |
| tick_i | input | 1 | Start strobe for one computation |
| pos_i | input | 3 | Hall sector index 0..5 |
| dir_rev_i | input | 1 | Rotation direction, 1 = reverse |
| cnt_i | input | CNT_W | Ticks elapsed in the current sector |
| period_i | input | CNT_W | Ticks of the last full sector |
| speed_abs_i | input | SPD_W | Absolute motor speed |
| spd_thr_i | input | SPD_W | Speed above which advance may apply |
| adv_en_i | input | 1 | Phase advance enable |
| duty_i | input | DUTY_W | Signed duty command |
| bp_start_i | input | DUTY_W | Signed first duty breakpoint |
| bp_step_i | input | DUTY_W | Breakpoint spacing |
| adv_tab_i | input | NPTS*TAB_W | Advance table, signed entries packed upward |
| angle_raw_o | output | ANG_W | Interpolated angle in degrees, signed |
| angle_adv_o | output | ANG_W | Advanced angle in degrees, signed |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The delicate overlap is a disable arriving while a computation sits between its two stages. The disable clear and the result completion then compete for the same output registers on the same edge. The bench provokes this by lowering `en_i` in the cycle right after a tick has been accepted. It then requires `valid_o` to stay low and both angles to read zero at the edge where the result would otherwise have landed. A second overlap is the gate and the wrap acting on one result whose raw angle is exactly 360; this result must come out as 0 only when the gate is open.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int FRAC_BITS  = 31;
  localparam int SECTOR_DEG = 60;
  localparam int TURN_DEG   = 360;

  // Interpolated angle inside a Hall sector; period of 0 contributes nothing.
  function automatic int sector_angle(input int pos, input bit rev,
                                      input int cnt, input int per);
    int base;
    int q;
    base = rev ? pos + 1 : pos;
    q    = (per == 0) ? 0 : (SECTOR_DEG * cnt) / per;
    return (rev ? -q : q) + base * SECTOR_DEG;
  endfunction

  // Modulo whose result takes the sign of the divisor.
  function automatic int floor_mod(input int v, input int m);
    int r;
    r = v % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  // Linear blend of two table points with a Q31 weight, rounded toward -inf.
  function automatic int lerp_q31(input int lo, input int hi, input longint frac);
    longint d;
    d = longint'(hi) - longint'(lo);
    return int'((d * frac) >>> FRAC_BITS) + lo;
  endfunction

endpackage

// File: rtl/eag_raw_angle.sv
module eag_raw_angle #(
  parameter int CNT_W = 16,
  parameter int ANG_W = 16
) (
  input  logic                    rev_i,
  input  logic [2:0]              pos_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        period_i,
  output logic signed [ANG_W-1:0] angle_o
);

  int ang_full;

  assign ang_full = eag_pkg::sector_angle(int'(pos_i), rev_i, int'(cnt_i), int'(period_i));
  assign angle_o  = ANG_W'(ang_full);

endmodule

// File: rtl/eag_adv_lookup.sv
module eag_adv_lookup #(
  parameter int DUTY_W = 16,
  parameter int TAB_W  = 16,
  parameter int NPTS   = 11
) (
  input  logic signed [DUTY_W-1:0] duty_i,
  input  logic signed [DUTY_W-1:0] bp_start_i,
  input  logic [DUTY_W-1:0]        bp_step_i,
  input  logic [NPTS*TAB_W-1:0]    tab_i,
  output logic signed [TAB_W-1:0]  adv_o
);

  localparam int NSEG  = NPTS - 1;
  localparam int SEG_W = $clog2(NPTS);
  localparam longint ONE_Q31 = longint'(1) <<< eag_pkg::FRAC_BITS;

  logic signed [TAB_W-1:0] pts [NPTS];

  generate
    for (genvar g = 0; g < NPTS; g++) begin : g_unpack
      assign pts[g] = tab_i[g*TAB_W +: TAB_W];
    end
  endgenerate

  int          mag;
  int          start;
  int          step;
  longint      above;
  longint      whole;
  longint      frac;
  logic [SEG_W-1:0] seg;
  int          blend;

  // Segment and Q31 fraction of the duty magnitude on the even grid.
  always_comb begin
    mag   = (duty_i < 0) ? -int'(duty_i) : int'(duty_i);
    start = int'(bp_start_i);
    step  = int'(bp_step_i);
    above = 0;
    whole = 0;
    seg   = '0;
    frac  = 0;
    if (mag > start) begin
      above = longint'(mag) - longint'(start);
      whole = (step == 0) ? longint'(NSEG) : above / longint'(step);
      if (whole < longint'(NSEG)) begin
        seg  = SEG_W'(whole);
        frac = ((above - whole * longint'(step)) <<< eag_pkg::FRAC_BITS) / longint'(step);
      end else begin
        seg  = SEG_W'(NSEG - 1);
        frac = ONE_Q31;
      end
    end
  end

  assign blend = eag_pkg::lerp_q31(int'(pts[seg]), int'(pts[seg + 1'b1]), frac);
  assign adv_o = TAB_W'(blend);

endmodule

// File: rtl/elec_angle_gen.sv
module elec_angle_gen #(
  parameter int CNT_W  = 16,
  parameter int SPD_W  = 16,
  parameter int DUTY_W = 16,
  parameter int TAB_W  = 16,
  parameter int ANG_W  = 16,
  parameter int NPTS   = 11
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     tick_i,
  input  logic [2:0]               pos_i,
  input  logic                     dir_rev_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [SPD_W-1:0]         speed_abs_i,
  input  logic [SPD_W-1:0]         spd_thr_i,
  input  logic                     adv_en_i,
  input  logic signed [DUTY_W-1:0] duty_i,
  input  logic signed [DUTY_W-1:0] bp_start_i,
  input  logic [DUTY_W-1:0]        bp_step_i,
  input  logic [NPTS*TAB_W-1:0]    adv_tab_i,
  output logic signed [ANG_W-1:0]  angle_raw_o,
  output logic signed [ANG_W-1:0]  angle_adv_o,
  output logic                     valid_o
);

  logic signed [ANG_W-1:0] raw_w;
  logic signed [TAB_W-1:0] adv_w;
  logic                    gate_w;

  eag_raw_angle #(.CNT_W(CNT_W), .ANG_W(ANG_W)) u_raw (
    .rev_i    (dir_rev_i),
    .pos_i    (pos_i),
    .cnt_i    (cnt_i),
    .period_i (period_i),
    .angle_o  (raw_w)
  );

  eag_adv_lookup #(.DUTY_W(DUTY_W), .TAB_W(TAB_W), .NPTS(NPTS)) u_lut (
    .duty_i     (duty_i),
    .bp_start_i (bp_start_i),
    .bp_step_i  (bp_step_i),
    .tab_i      (adv_tab_i),
    .adv_o      (adv_w)
  );

  assign gate_w = adv_en_i && (speed_abs_i > spd_thr_i);

  // Stage 1: captured sector angle, table advance and gate decision.
  logic                    s1_vld;
  logic signed [ANG_W-1:0] raw_q;
  logic signed [TAB_W-1:0] adv_q;
  logic                    gate_q;
  logic                    rev_q;

  // Stage 2 arithmetic: signed advance plus raw angle, folded into one turn.
  int adv_signed;
  int adv_sum;
  int adv_wrap;

  assign adv_signed = rev_q ? -int'(adv_q) : int'(adv_q);
  assign adv_sum    = adv_signed + int'(raw_q);
  assign adv_wrap   = eag_pkg::floor_mod(adv_sum, eag_pkg::TURN_DEG);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      s1_vld      <= 1'b0;
      raw_q       <= '0;
      adv_q       <= '0;
      gate_q      <= 1'b0;
      rev_q       <= 1'b0;
      angle_raw_o <= '0;
      angle_adv_o <= '0;
      valid_o     <= 1'b0;
    end else begin
      s1_vld  <= tick_i;
      valid_o <= s1_vld;
      if (tick_i) begin
        raw_q  <= raw_w;
        adv_q  <= adv_w;
        gate_q <= gate_w;
        rev_q  <= dir_rev_i;
      end
      if (s1_vld) begin
        angle_raw_o <= raw_q;
        angle_adv_o <= gate_q ? ANG_W'(adv_wrap) : raw_q;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s1_vld) |=> valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s1_vld)); // R2
  AST_GATE_CLOSED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s1_vld && !gate_q) |=> (angle_adv_o == angle_raw_o)); // R4
  AST_WRAP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s1_vld && gate_q) |=> (angle_adv_o >= 0 && angle_adv_o < 360)); // R8
  AST_DISABLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (angle_raw_o == 0 && angle_adv_o == 0 && !valid_o)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !s1_vld) |=> ($stable(angle_raw_o) && $stable(angle_adv_o))); // R10

endmodule

// File: tb/elec_angle_gen_tb.sv
module elec_angle_gen_tb_top;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b1;
  logic               tick = 1'b0;
  logic [2:0]         pos = '0;
  logic               rev = 1'b0;
  logic [15:0]        cnt = '0;
  logic [15:0]        per = 16'd1;
  logic [15:0]        spd = '0;
  logic [15:0]        thr = 16'd400;
  logic               aen = 1'b0;
  logic signed [15:0] duty = '0;
  logic signed [15:0] bp0 = 16'sd100;
  logic [15:0]        bstep = 16'd100;
  logic [175:0]       tab = '0;
  logic signed [15:0] ang_raw;
  logic signed [15:0] ang_adv;
  logic               vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  elec_angle_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .pos_i(pos), .dir_rev_i(rev), .cnt_i(cnt), .period_i(per),
    .speed_abs_i(spd), .spd_thr_i(thr), .adv_en_i(aen), .duty_i(duty),
    .bp_start_i(bp0), .bp_step_i(bstep), .adv_tab_i(tab),
    .angle_raw_o(ang_raw), .angle_adv_o(ang_adv), .valid_o(vld)
  );

  typedef struct packed {
    logic [2:0]         pos;
    logic               rev;
    logic [15:0]        cnt;
    logic [15:0]        per;
    logic [15:0]        spd;
    logic signed [15:0] duty;
    logic               aen;
    logic signed [15:0] xraw;
    logic signed [15:0] xadv;
  } vec_t;

  // Table t = 0,3,6,9,12,15,18,20,22,24,21; start 100, step 100, threshold 400.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'd0,  16'd100, 16'd0,    16'sd0,     1'b1, 16'sd0,   16'sd0},
    '{3'd2, 1'b0, 16'd50, 16'd100, 16'd500,  16'sd350,   1'b1, 16'sd150, 16'sd157},
    '{3'd3, 1'b1, 16'd20, 16'd60,  16'd401,  -16'sd1100, 1'b1, 16'sd220, 16'sd199},
    '{3'd0, 1'b1, 16'd50, 16'd60,  16'd1000, 16'sd600,   1'b1, 16'sd10,  16'sd355},
    '{3'd1, 1'b0, 16'd10, 16'd40,  16'd400,  16'sd600,   1'b1, 16'sd75,  16'sd75},
    '{3'd4, 1'b0, 16'd0,  16'd50,  16'd900,  16'sd600,   1'b0, 16'sd240, 16'sd240},
    '{3'd5, 1'b0, 16'd40, 16'd40,  16'd900,  16'sd100,   1'b1, 16'sd360, 16'sd0},
    '{3'd1, 1'b0, 16'd0,  16'd10,  16'd500,  16'sd1050,  1'b1, 16'sd60,  16'sd82},
    '{3'd2, 1'b1, 16'd7,  16'd9,   16'd10,   16'sd600,   1'b1, 16'sd134, 16'sd134},
    '{3'd0, 1'b0, 16'd0,  16'd1,   16'd401,  16'sd175,   1'b1, 16'sd0,   16'sd2}
  };

  localparam string VTAG [NV] = '{
    "R3 idle sector", "R7 half segment", "R6 clip reverse", "R8 negative wrap",
    "R4 speed equal", "R4 advance off", "R5 first point", "R7 floor blend",
    "R3 truncation", "R7 quarter step"
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    pos = v.pos; rev = v.rev; cnt = v.cnt; per = v.per;
    spd = v.spd; duty = v.duty; aen = v.aen; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int pts [11] = '{0, 3, 6, 9, 12, 15, 18, 20, 22, 24, 21};
    for (int k = 0; k < 11; k++) tab[k*16 +: 16] = 16'(pts[k]);
    repeat (3) @(negedge clk);
    chk("R1 raw in reset", int'(ang_raw), 0);
    chk("R1 valid in reset", int'(vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 raw after reset", int'(ang_raw), 0);
    chk("R1 adv after reset", int'(ang_adv), 0);
    chk("R1 valid after reset", int'(vld), 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk({"R2 valid ", VTAG[i]}, int'(vld), 1);
      chk({VTAG[i], " raw"}, int'(ang_raw), int'(VECS[i].xraw));
      chk({VTAG[i], " adv"}, int'(ang_adv), int'(VECS[i].xadv));
      @(negedge clk);
      chk({"R2 single pulse ", VTAG[i]}, int'(vld), 0);
    end

    // R10: inputs change without a tick; last result must stay.
    pos = 3'd4; cnt = 16'd9; duty = 16'sd900; spd = 16'd2000;
    repeat (3) @(negedge clk);
    chk("R10 raw held", int'(ang_raw), 0);
    chk("R10 adv held", int'(ang_adv), 2);

    // R9: in-flight result discarded when disable follows the tick.
    apply(VECS[1]);
    @(negedge clk);
    pos = 3'd2; cnt = 16'd50; per = 16'd100; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; en = 1'b0;
    @(negedge clk);
    chk("R9 in-flight valid", int'(vld), 0);
    chk("R9 raw forced zero", int'(ang_raw), 0);
    chk("R9 adv forced zero", int'(ang_adv), 0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 tick ignored valid", int'(vld), 0);
    chk("R9 tick ignored raw", int'(ang_raw), 0);
    en = 1'b1;
    apply(VECS[6]);
    chk("R9 resumes raw", int'(ang_raw), 360);
    chk("R8 resumes wrapped", int'(ang_adv), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule